// File: doc/BRIEF.md
# Tick Timer with Match Modes

This block is the tick timer of a processor core. It holds a 32-bit count register that advances by one on each cycle in which the tick enable input is high, and a control word that sets a match period, an interrupt enable, a sticky pending flag and a two-bit operating mode. Software writes and reads both registers through a one-cycle register port. A select bit chooses the register.

A match occurs on a tick that brings the low 28 bits of the count to the period value. The upper four count bits take no part in the compare. The mode decides what happens at a match. In restart mode the count returns to zero. In one-shot mode counting halts. In continuous mode the count keeps running. In off mode nothing counts at all. When interrupts are enabled, a match latches the pending flag, and the interrupt output follows that flag until software clears it. The tick enable is normally a 20 MHz strobe, so one tick lasts 50 ns.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the count reads 0, the control word reads 0x0000_0000 and `irq` is low.
- R2: In an active mode that is not halted, each cycle with `tick_en` high and no register write adds one to the count. A cycle with `tick_en` low leaves the count unchanged.
- R3: In off mode (mode field `2'b00`), ticks leave the count unchanged.
- R4: A match is a counting tick whose incremented count has bits [27:0] equal to the period field, which is bits [27:0] of the control word. Count bits [31:28] are ignored in the compare.
- R5: In restart mode (`2'b01`) a match loads the count with zero instead of the period value.
- R6: In one-shot mode (`2'b10`) a match stores the period value and then halts counting. The count holds until the next write to the control word, which resumes counting.
- R7: In continuous mode (`2'b11`) the count keeps advancing past a match. A new match occurs when the low field comes round to the period again, including after it wraps.
- R8: When interrupt enable (control bit 29) is 1, a match sets the pending flag (control bit 28), and `irq` is then high.
- R9: When interrupt enable is 0, a match leaves the pending flag and `irq` at 0.
- R10: The pending flag stays set until a control write with bit 28 equal to 0. A control write with bit 28 equal to 1 never sets the flag.
- R11: A register write in the same cycle as a tick wins. The written register takes the written value, and that tick causes no count change and no match.
- R12: `rd_data` shows the count when `rd_sel` is 0. When `rd_sel` is 1 it shows the control word {mode[31:30], enable[29], pending[28], period[27:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Count strobe, one tick per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 count, 1 control word |
| wr_data | input | 32 | Write value |
| rd_sel | input | 1 | Read source: 0 count, 1 control word |
| rd_data | output | 32 | Selected register value |
| irq | output | 1 | Timer interrupt, equals the pending flag |

## Verification
The embedded properties are checked on every cycle. They cover five rules: the count does not move in off mode or while a one-shot is halted, a counting tick adds exactly one, a restart match gives zero, and a write lands its value on the next cycle. On the control side they also check that the pending flag is sticky and that it cannot rise while interrupts are disabled. Only the directed scenarios show the full sequences: the restart period length, the one-shot stop at the period value and its resume on a control write, a continuous match after the low field wraps with nonzero upper bits, and the exact value read back from the control word.

// File: rtl/tt_pkg.sv
// Package: shared types and field positions for the tick timer.
// Assumes a 4-bit control header above the period field.
package tt_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_RESTART = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_CONT    = 2'b11
    } tt_mode_e;
endpackage

// File: rtl/tt_match.sv
// Module: compares the low field of the incremented count with the period.
// Assumes the caller qualifies the result with a counting tick.
module tt_match #(
    parameter int PER_W = 28
) (
    input  logic [PER_W-1:0] next_low,
    input  logic [PER_W-1:0] period,
    output logic             hit
);
    // Equality of the low field only; upper count bits never reach here.
    always_comb hit = (next_low == period);
endmodule

// File: rtl/tt_counter.sv
// Module: the count register. A write loads it. A step either increments
// it or clears it on a restart match. Assumes step is low in write cycles.
module tt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             step,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] next_count
);
    // Incremented value offered to the comparator.
    always_comb next_count = count + CNT_W'(1);

    // Count register update: write, then step, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (wr_cnt)  count <= wr_data;
        else if (step)    count <= restart ? '0 : next_count;
    end

    a_r11_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> count == $past(wr_data));
    a_r2_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !wr_cnt) |=> count == $past(count) + CNT_W'(1));
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && restart && !wr_cnt) |=> count == '0);
endmodule

// File: rtl/tt_ctrl.sv
// Module: control word (period, enable, pending, mode) plus the one-shot
// halt flag. Assumes match_evt is low in write cycles.
module tt_ctrl
    import tt_pkg::*;
#(
    parameter int PER_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl,
    input  logic [PER_W+3:0] wr_data,
    input  logic             match_evt,
    output logic [PER_W-1:0] period,
    output logic             int_en,
    output logic             pending,
    output tt_mode_e         mode,
    output logic             halted
);
    localparam int PEND_BIT = PER_W;
    localparam int IE_BIT   = PER_W + 1;
    localparam int MODE_LSB = PER_W + 2;

    // Control fields load on a write and otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            int_en <= 1'b0;
            mode   <= MODE_OFF;
        end else if (wr_ctl) begin
            period <= wr_data[PER_W-1:0];
            int_en <= wr_data[IE_BIT];
            mode   <= tt_mode_e'(wr_data[MODE_LSB +: 2]);
        end
    end

    // Pending flag: set by an enabled match, cleared only by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         pending <= 1'b0;
        else if (wr_ctl)    pending <= pending & wr_data[PEND_BIT];
        else if (match_evt) pending <= pending | int_en;
    end

    // Halt flag: a one-shot match sets it and any control write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)         halted <= 1'b0;
        else if (wr_ctl)    halted <= 1'b0;
        else if (match_evt && mode == MODE_ONESHOT) halted <= 1'b1;
    end

    a_r10_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(wr_ctl && !wr_data[PEND_BIT])) |=> pending);
    a_r9_no_pend_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && !int_en && !wr_ctl) |=> !pending);
    a_r10_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && wr_ctl) |=> !pending);
endmodule

// File: rtl/tick_timer.sv
// Module: top of the tick timer. It ties the counter, the comparator and
// the control word together and muxes the read port. Assumes tick_en is
// a single-cycle strobe in the clk domain.
module tick_timer
    import tt_pkg::*;
#(
    parameter int PER_W = 28
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_en,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [PER_W+3:0]     wr_data,
    input  logic                 rd_sel,
    output logic [PER_W+3:0]     rd_data,
    output logic                 irq
);
    localparam int REG_W = PER_W + 4;

    logic [REG_W-1:0] count;
    logic [REG_W-1:0] next_count;
    logic [PER_W-1:0] period;
    logic             int_en;
    logic             pending;
    tt_mode_e         mode;
    logic             halted;
    logic             hit;
    logic             step;
    logic             match_evt;
    logic             restart;

    // A tick counts only in an active, unhalted mode and without a write.
    always_comb begin
        step      = tick_en && !wr_en && (mode != MODE_OFF) && !halted;
        match_evt = step && hit;
        restart   = match_evt && (mode == MODE_RESTART);
    end

    tt_counter #(.CNT_W(REG_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cnt     (wr_en && !wr_sel),
        .wr_data    (wr_data),
        .step       (step),
        .restart    (restart),
        .count      (count),
        .next_count (next_count)
    );

    tt_match #(.PER_W(PER_W)) u_match (
        .next_low (next_count[PER_W-1:0]),
        .period   (period),
        .hit      (hit)
    );

    tt_ctrl #(.PER_W(PER_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl    (wr_en && wr_sel),
        .wr_data   (wr_data),
        .match_evt (match_evt),
        .period    (period),
        .int_en    (int_en),
        .pending   (pending),
        .mode      (mode),
        .halted    (halted)
    );

    // Read mux and interrupt output.
    always_comb begin
        rd_data = rd_sel ? {mode, int_en, pending, period} : count;
        irq     = pending;
    end

    a_r3_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF && !wr_en) |=> $stable(count));
    a_r6_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !wr_en) |=> $stable(count));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd_cnt(string req, logic [31:0] exp);
        rd_sel = 1'b0; #1; chk(req, rd_data, exp);
    endtask

    task automatic rd_ctl(string req, logic [31:0] exp);
        rd_sel = 1'b1; #1; chk(req, rd_data, exp);
    endtask

    task automatic chk_irq(string req, logic exp);
        chk(req, {31'b0, irq}, {31'b0, exp});
    endtask

    // One clock cycle with the given inputs, ending at a falling edge.
    task automatic cyc(logic w, logic sel, logic [31:0] d, logic t);
        wr_en = w; wr_sel = sel; wr_data = d; tick_en = t;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; tick_en = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b1);
    endtask

    task automatic t_reset();
        rd_cnt("R1 count", 32'h0);
        rd_ctl("R1 ctrl", 32'h0);
        chk_irq("R1 irq", 1'b0);
    endtask

    task automatic t_off();
        cyc(1'b1, 1'b0, 32'd5, 1'b0);
        rd_cnt("R12 count readback", 32'd5);
        ticks(3);
        rd_cnt("R3 off mode holds", 32'd5);
    endtask

    task automatic t_count();
        cyc(1'b1, 1'b0, 32'd0, 1'b0);
        cyc(1'b1, 1'b1, 32'hC000_0064, 1'b0);
        ticks(4);
        rd_cnt("R2 four ticks", 32'd4);
        cyc(1'b0, 1'b0, '0, 1'b0);
        cyc(1'b0, 1'b0, '0, 1'b0);
        rd_cnt("R2 no tick holds", 32'd4);
    endtask

    task automatic t_restart();
        cyc(1'b1, 1'b0, 32'd0, 1'b0);
        cyc(1'b1, 1'b1, 32'h6000_0003, 1'b0);
        ticks(2);
        rd_cnt("R5 before match", 32'd2);
        chk_irq("R8 no irq before match", 1'b0);
        ticks(1);
        rd_cnt("R5 restart to zero", 32'd0);
        chk_irq("R8 irq on match", 1'b1);
        rd_ctl("R8 pending readback", 32'h7000_0003);
        cyc(1'b1, 1'b1, 32'h7000_0003, 1'b0);
        chk_irq("R10 write 1 keeps pending", 1'b1);
        cyc(1'b1, 1'b1, 32'h6000_0003, 1'b0);
        chk_irq("R10 write 0 clears", 1'b0);
        cyc(1'b1, 1'b1, 32'h7000_0003, 1'b0);
        chk_irq("R10 write 1 does not set", 1'b0);
        ticks(3);
        rd_cnt("R5 second period", 32'd0);
        chk_irq("R8 second match", 1'b1);
    endtask

    task automatic t_masked();
        cyc(1'b1, 1'b1, 32'h4000_0002, 1'b0);
        cyc(1'b1, 1'b0, 32'd0, 1'b0);
        ticks(2);
        rd_cnt("R9 restart masked", 32'd0);
        chk_irq("R9 no pending when masked", 1'b0);
    endtask

    task automatic t_oneshot();
        cyc(1'b1, 1'b0, 32'd0, 1'b0);
        cyc(1'b1, 1'b1, 32'h8000_0004, 1'b0);
        ticks(6);
        rd_cnt("R6 halts at period", 32'd4);
        cyc(1'b1, 1'b1, 32'h8000_0004, 1'b0);
        ticks(1);
        rd_cnt("R6 resumes after write", 32'd5);
    endtask

    task automatic t_cont();
        cyc(1'b1, 1'b1, 32'hE000_0001, 1'b0);
        cyc(1'b1, 1'b0, 32'h0FFF_FFFF, 1'b0);
        ticks(1);
        rd_cnt("R7 wrap low field", 32'h1000_0000);
        chk_irq("R4 no match at zero", 1'b0);
        ticks(1);
        rd_cnt("R7 keeps value", 32'h1000_0001);
        chk_irq("R4 upper bits ignored", 1'b1);
        ticks(1);
        rd_cnt("R7 keeps running", 32'h1000_0002);
    endtask

    task automatic t_priority();
        cyc(1'b1, 1'b1, 32'hC000_0FFF, 1'b0);
        cyc(1'b1, 1'b0, 32'h20, 1'b1);
        rd_cnt("R11 count write beats tick", 32'h20);
        cyc(1'b1, 1'b1, 32'hC000_0021, 1'b1);
        rd_cnt("R11 ctrl write blocks tick", 32'h20);
        rd_ctl("R12 ctrl readback", 32'hC000_0021);
        chk_irq("R11 no match in write cycle", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_off();
        t_count();
        t_restart();
        t_masked();
        t_oneshot();
        t_cont();
        t_priority();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule